// File: doc/BRIEF.md
# Accumulator Processor with Memory Stack

This block is a small multi-cycle processor built around one accumulator. It fetches 16-bit instruction words from a single word-addressed memory, decodes them and executes them. The same memory holds both program and data. The top four bits of a word select the operation. The low twelve bits give a memory address or a jump target. The memory port is synchronous: the block presents an address, plus write data and a write strobe when it stores, and the read word comes back on the cycle after the address.

Subroutine linkage and data stacking use a stack held in ordinary memory. The stack starts at the top of the address space and grows toward address zero. Both the entry of a call and a push lower the stack pointer first and then write at the lowered location. Both a return and a pop read at the pointer first and then raise it. A halt instruction freezes the machine until reset. The current program counter, accumulator and stack pointer are brought out on debug ports so that a test environment can observe the architectural state.

Top module: `acc_cpu_core`

## Requirements
- R1: Each instruction takes one fetch cycle, one decode cycle and one execute cycle. LD, ADD, SUB, POP and RET add one write-back cycle. Read data is used on the cycle after its address was driven. After the execute cycle of HALT, `halted` goes high.
- R2: An instruction word holds the opcode in bits [15:12] and an address in bits [11:0]. The opcodes are 0 LD, 1 ST, 2 ADD, 3 SUB, 4 INC, 5 DEC, 6 JMP, 7 JZ, 8 PUSH, 9 POP, A CALL, B RET and F HALT.
- R3: While reset is applied, PC reads 0, ACC reads 0, SP reads 0xFFF, `halted` is low and no memory write is issued.
- R4: LD copies M[addr] into ACC. ST writes ACC to M[addr]. ADD and SUB set ACC to ACC+M[addr] and ACC-M[addr], modulo 2^16.
- R5: INC and DEC add one to ACC or subtract one from it, modulo 2^16. 0xFFFF+1 gives 0 and 0-1 gives 0xFFFF.
- R6: JMP loads PC with the address field. JZ does the same only when the zero flag is set. The zero flag is set at reset and is recomputed from ACC by every instruction that writes ACC (LD, ADD, SUB, INC, DEC, POP). When JZ is not taken, execution continues at the next word.
- R7: PUSH first lowers SP by one, then writes ACC at the new SP. POP reads M[SP] into ACC, then raises SP by one. SP wraps modulo 4096, so a POP at SP 0xFFF leaves SP at 0x000.
- R8: CALL first lowers SP by one, then writes the return address (the CALL's own address plus one, zero-extended) at the new SP, then loads PC with the target.
- R9: RET loads PC from bits [11:0] of M[SP], then raises SP by one. Nested calls return in reverse order and leave SP where it started.
- R10: After HALT, PC holds the HALT's address plus one. PC, ACC and SP then stay constant and no write occurs until reset.
- R11: Opcodes C, D and E change neither ACC, PC flow, SP nor memory, and take three cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid the cycle after the address |
| halted | output | 1 | High once HALT has executed |
| dbg_pc | output | 12 | Program counter |
| dbg_acc | output | 16 | Accumulator |
| dbg_sp | output | 12 | Stack pointer |

## Verification
Hand-written programs target specific behaviours:
- Nested CALL/RET with a push and pop inside the inner routine checks that the pointer is lowered before the write and raised after the read, in the right order.
- A taken and a not-taken JZ check the branch against the zero flag.
- A wrap program runs INC on 0xFFFF and POP at the top of the stack.
- A program built of unused opcodes checks that they do nothing.

Seeded random straight-line programs with forward jumps, balanced push/pop and calls to a short routine separate arithmetic, store and flag errors. These runs compare every memory write in order, the final state and the total cycle count against an instruction-level model.

// File: rtl/acp_pkg.sv
package acp_pkg;

  typedef enum logic [3:0] {
    OP_LD   = 4'h0,
    OP_ST   = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_INC  = 4'h4,
    OP_DEC  = 4'h5,
    OP_JMP  = 4'h6,
    OP_JZ   = 4'h7,
    OP_PUSH = 4'h8,
    OP_POP  = 4'h9,
    OP_CALL = 4'hA,
    OP_RET  = 4'hB,
    OP_RSVC = 4'hC,
    OP_RSVD = 4'hD,
    OP_RSVE = 4'hE,
    OP_HALT = 4'hF
  } opcode_t;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_WBACK  = 3'd3,
    PH_HALT   = 3'd4
  } phase_t;

  // operations whose memory read completes in a write-back cycle
  function automatic logic needs_read(opcode_t op);
    return (op == OP_LD) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_POP) || (op == OP_RET);
  endfunction

  // operations that lower the stack pointer before their write
  function automatic logic stack_down(opcode_t op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/acp_rst_sync.sv
module acp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acp_ctrl.sv
module acp_ctrl
  import acp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_t exec_op,
  output phase_t  phase
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_FETCH:  phase_d = PH_DECODE;
      PH_DECODE: phase_d = PH_EXEC;
      PH_EXEC: begin
        if (exec_op == OP_HALT)       phase_d = PH_HALT;
        else if (needs_read(exec_op)) phase_d = PH_WBACK;
        else                          phase_d = PH_FETCH;
      end
      PH_WBACK:  phase_d = PH_FETCH;
      PH_HALT:   phase_d = PH_HALT;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R1: decode always follows a fetch
  a_r1_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_DECODE |-> $past(phase_q) == PH_FETCH);

  // R1: write-back only for reading operations
  a_r1_wback_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_WBACK |-> ($past(phase_q) == PH_EXEC) && needs_read(exec_op));

  // R10: halt state is absorbing
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_HALT |=> phase_q == PH_HALT);
endmodule

// File: rtl/acp_alu.sv
module acp_alu
  import acp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_t           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              is_zero
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      OP_LD, OP_POP: result = operand;
      OP_ADD:        result = acc + operand;
      OP_SUB:        result = acc - operand;
      OP_INC:        result = acc + ONE;
      OP_DEC:        result = acc - ONE;
      default:       result = acc;
    endcase
    is_zero = (result == '0);
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [ADDR_W-1:0] dbg_sp
);
  localparam int OPC_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] SP_INIT = '1;
  localparam logic [ADDR_W-1:0] A_ONE   = ADDR_W'(1);

  logic   rst_core_n;
  phase_t phase;

  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic [DATA_W-1:0] acc_q, acc_d, ir_q, ir_d;
  logic              zf_q, zf_d;
  logic              en_pc, en_sp, en_acc, en_ir, en_zf;

  opcode_t           ir_op, fetch_op;
  logic [ADDR_W-1:0] field;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;

  assign ir_op    = opcode_t'(ir_q[DATA_W-1 -: OPC_W]);
  assign fetch_op = opcode_t'(mem_rdata[DATA_W-1 -: OPC_W]);
  assign field    = ir_q[ADDR_W-1:0];

  acp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  acp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .exec_op(ir_op), .phase(phase));

  acp_alu #(.DATA_W(DATA_W)) u_alu (
    .op(ir_op), .acc(acc_q), .operand(mem_rdata),
    .result(alu_res), .is_zero(alu_zero));

  // memory request
  always_comb begin
    mem_addr  = pc_q;
    mem_we    = 1'b0;
    mem_wdata = acc_q;
    if (phase == PH_EXEC) begin
      case (ir_op)
        OP_LD, OP_ADD, OP_SUB: mem_addr = field;
        OP_ST: begin
          mem_addr = field;
          mem_we   = 1'b1;
        end
        OP_PUSH: begin
          mem_addr = sp_q;
          mem_we   = 1'b1;
        end
        OP_CALL: begin
          mem_addr  = sp_q;
          mem_we    = 1'b1;
          mem_wdata = {{OPC_W{1'b0}}, pc_q};
        end
        OP_POP, OP_RET: mem_addr = sp_q;
        default: mem_addr = pc_q;
      endcase
    end
  end

  // architectural next state
  always_comb begin
    pc_d   = pc_q;   en_pc  = 1'b0;
    sp_d   = sp_q;   en_sp  = 1'b0;
    acc_d  = acc_q;  en_acc = 1'b0;
    ir_d   = ir_q;   en_ir  = 1'b0;
    zf_d   = zf_q;   en_zf  = 1'b0;
    case (phase)
      PH_DECODE: begin
        ir_d  = mem_rdata;
        en_ir = 1'b1;
        pc_d  = pc_q + A_ONE;
        en_pc = 1'b1;
        if (stack_down(fetch_op)) begin
          sp_d  = sp_q - A_ONE;
          en_sp = 1'b1;
        end
      end
      PH_EXEC: begin
        case (ir_op)
          OP_INC, OP_DEC: begin
            acc_d = alu_res;  en_acc = 1'b1;
            zf_d  = alu_zero; en_zf  = 1'b1;
          end
          OP_JMP, OP_CALL: begin
            pc_d = field; en_pc = 1'b1;
          end
          OP_JZ: begin
            pc_d  = field;
            en_pc = zf_q;
          end
          default: ;
        endcase
      end
      PH_WBACK: begin
        case (ir_op)
          OP_LD, OP_ADD, OP_SUB: begin
            acc_d = alu_res;  en_acc = 1'b1;
            zf_d  = alu_zero; en_zf  = 1'b1;
          end
          OP_POP: begin
            acc_d = alu_res;  en_acc = 1'b1;
            zf_d  = alu_zero; en_zf  = 1'b1;
            sp_d  = sp_q + A_ONE; en_sp = 1'b1;
          end
          OP_RET: begin
            pc_d = mem_rdata[ADDR_W-1:0]; en_pc = 1'b1;
            sp_d = sp_q + A_ONE;          en_sp = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= '0;
      sp_q  <= SP_INIT;
      acc_q <= '0;
      ir_q  <= '0;
      zf_q  <= 1'b1;
    end else begin
      if (en_pc)  pc_q  <= pc_d;
      if (en_sp)  sp_q  <= sp_d;
      if (en_acc) acc_q <= acc_d;
      if (en_ir)  ir_q  <= ir_d;
      if (en_zf)  zf_q  <= zf_d;
    end
  end

  assign halted  = (phase == PH_HALT);
  assign dbg_pc  = pc_q;
  assign dbg_acc = acc_q;
  assign dbg_sp  = sp_q;

  // R4: writes only during an execute cycle
  a_r4_write_in_exec: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |-> phase == PH_EXEC);

  // R6: zero flag agrees with the accumulator
  a_r6_zero_tracks_acc: assert property (@(posedge clk) disable iff (!rst_core_n)
    zf_q == (acc_q == '0));

  // R8: call writes at a pointer lowered by one since its fetch
  a_r8_call_predec: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase == PH_EXEC && ir_op == OP_CALL) |-> (mem_we && sp_q == $past(sp_q, 2) - A_ONE));

  // R9: return raises the pointer after reading the target
  a_r9_ret_postinc: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase == PH_FETCH && $past(phase) == PH_WBACK && $past(ir_op) == OP_RET)
      |-> (sp_q == $past(sp_q) + A_ONE && pc_q == $past(mem_rdata[ADDR_W-1:0])));

  // R10: no state change and no writes once halted
  a_r10_halt_frozen: assert property (@(posedge clk) disable iff (!rst_core_n)
    (phase == PH_HALT && $past(phase) == PH_HALT)
      |-> ($stable(pc_q) && $stable(acc_q) && $stable(sp_q) && !mem_we));
endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MEMN = 1 << AW;
  localparam int RUN_LIMIT = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;
  logic [AW-1:0] dbg_pc;
  logic [DW-1:0] dbg_acc;
  logic [AW-1:0] dbg_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_sp(dbg_sp));

  logic [DW-1:0] mem [MEMN];
  logic [DW-1:0] img [MEMN];
  logic [DW-1:0] mm  [MEMN];
  int            wr_cnt = 0;
  logic [AW-1:0] wr_a [1024];
  logic [DW-1:0] wr_d [1024];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr]      <= mem_wdata;
      wr_a[wr_cnt % 1024] <= mem_addr;
      wr_d[wr_cnt % 1024] <= mem_wdata;
      wr_cnt             <= wr_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int fails  = 0;
  int total_cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 190000) begin
      chk(1'b0, "R1", "global watchdog", total_cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // instruction-level reference model
  logic [AW-1:0] e_pc, e_sp;
  logic [DW-1:0] e_acc;
  int            e_cyc, e_wn;
  logic [AW-1:0] e_wa [256];
  logic [DW-1:0] e_wd [256];

  task automatic mwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mm[a] = d;
    if (e_wn < 256) begin e_wa[e_wn] = a; e_wd[e_wn] = d; end
    e_wn++;
  endtask

  task automatic model();
    logic [DW-1:0] ins;
    logic [AW-1:0] f;
    bit zf = 1'b1;
    bit done = 1'b0;
    for (int i = 0; i < MEMN; i++) mm[i] = img[i];
    e_pc = '0; e_sp = '1; e_acc = '0; e_cyc = 0; e_wn = 0;
    for (int step = 0; step < 2000 && !done; step++) begin
      ins  = mm[e_pc];
      f    = ins[AW-1:0];
      e_pc = e_pc + 1'b1;
      e_cyc += 3;
      case (ins[15:12])
        4'h0: begin e_acc = mm[f]; e_cyc++; end
        4'h1: mwrite(f, e_acc);
        4'h2: begin e_acc = e_acc + mm[f]; e_cyc++; end
        4'h3: begin e_acc = e_acc - mm[f]; e_cyc++; end
        4'h4: e_acc = e_acc + 1'b1;
        4'h5: e_acc = e_acc - 1'b1;
        4'h6: e_pc = f;
        4'h7: if (zf) e_pc = f;
        4'h8: begin e_sp = e_sp - 1'b1; mwrite(e_sp, e_acc); end
        4'h9: begin e_acc = mm[e_sp]; e_sp = e_sp + 1'b1; e_cyc++; end
        4'hA: begin e_sp = e_sp - 1'b1; mwrite(e_sp, {4'h0, e_pc}); e_pc = f; end
        4'hB: begin e_pc = mm[e_sp][AW-1:0]; e_sp = e_sp + 1'b1; e_cyc++; end
        4'hF: done = 1'b1;
        default: ;
      endcase
      if (ins[15:12] inside {4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9}) zf = (e_acc == '0);
    end
  endtask

  int c0 = 0;
  int last_start = 0;

  task automatic run(input string req, input bit calib);
    int n = 0;
    int mism = 0;
    int start;
    logic [AW-1:0] hp, hs;
    logic [DW-1:0] ha;
    int hw;
    rst_n = 1'b0;
    for (int i = 0; i < MEMN; i++) mem[i] = img[i];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dbg_pc == 0 && dbg_acc == 0 && dbg_sp == 12'hFFF && !halted && !mem_we,
        "R3", "reset state pc/acc/sp", {dbg_pc, dbg_sp}, {12'h000, 12'hFFF});
    model();
    start = wr_cnt;
    last_start = start;
    rst_n = 1'b1;
    while (!halted && n < RUN_LIMIT) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    if (n >= RUN_LIMIT) begin
      chk(1'b0, req, "run watchdog", n, RUN_LIMIT);
      return;
    end
    if (calib) begin
      c0 = n - e_cyc;
      chk(c0 >= 1 && c0 <= 4, "R1", "reset release latency", c0, 2);
    end else begin
      chk(n == c0 + e_cyc, "R1", "cycles to halt", n, c0 + e_cyc);
    end
    chk(dbg_pc == e_pc, req, "final pc", dbg_pc, e_pc);
    chk(dbg_acc == e_acc, req, "final acc", dbg_acc, e_acc);
    chk(dbg_sp == e_sp, req, "final sp", dbg_sp, e_sp);
    chk(wr_cnt - start == e_wn, req, "write count", wr_cnt - start, e_wn);
    for (int k = 0; k < e_wn && k < 256; k++)
      if (wr_a[(start + k) % 1024] != e_wa[k] || wr_d[(start + k) % 1024] != e_wd[k]) mism++;
    chk(mism == 0, req, "write order/address/data mismatches", mism, 0);
    hp = dbg_pc; ha = dbg_acc; hs = dbg_sp; hw = wr_cnt;
    repeat (8) @(negedge clk);
    chk(dbg_pc == hp && dbg_acc == ha && dbg_sp == hs && wr_cnt == hw && halted,
        "R10", "state frozen after halt", wr_cnt - hw, 0);
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < MEMN; i++) img[i] = '0;
  endtask

  task automatic gen_random();
    int len, depth;
    logic [3:0] op;
    logic [AW-1:0] f;
    clear_img();
    len = 16 + int'($urandom % 24);
    depth = 0;
    for (int i = 0; i < 16; i++)
      img[12'h800 + i] = ($urandom % 4 == 0) ? 16'h0000 : DW'($urandom);
    img[12'h400] = ins(4'h2, 12'h805);
    img[12'h401] = ins(4'hB, 12'h000);
    for (int i = 0; i < len; i++) begin
      op = 4'($urandom % 15);
      if (op == 4'hB) op = 4'h4;
      f = 12'h800 + 12'($urandom % 16);
      if (op == 4'h9 && depth == 0) op = 4'h8;
      if (op == 4'h8) depth++;
      if (op == 4'h9) depth--;
      if (op == 4'h6 || op == 4'h7) begin
        f = 12'(i + 1 + int'($urandom % 3));
        if (f > 12'(len)) f = 12'(len);
      end
      if (op == 4'hA) f = 12'h400;
      img[i] = ins(op, f);
    end
    img[len] = ins(4'hF, 12'h000);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));

    // D1: halt only, calibrates reset-release latency
    clear_img();
    img[0] = ins(4'hF, 12'h000);
    run("R10", 1'b1);
    chk(dbg_pc == 12'h001, "R10", "pc after halt at 0", dbg_pc, 1);

    // D2: nested call/return with push/pop in inner routine
    clear_img();
    img[12'h800] = 16'd5;
    img[0] = ins(4'h0, 12'h800);
    img[1] = ins(4'hA, 12'h100);
    img[2] = ins(4'h1, 12'h801);
    img[3] = ins(4'hF, 12'h000);
    img[12'h100] = ins(4'h4, 12'h000);
    img[12'h101] = ins(4'hA, 12'h200);
    img[12'h102] = ins(4'hB, 12'h000);
    img[12'h200] = ins(4'h8, 12'h000);
    img[12'h201] = ins(4'h5, 12'h000);
    img[12'h202] = ins(4'h9, 12'h000);
    img[12'h203] = ins(4'hB, 12'h000);
    run("R8", 1'b0);
    chk(wr_a[last_start % 1024] == 12'hFFE && wr_d[last_start % 1024] == 16'h0002,
        "R8", "outer call return address at FFE", wr_d[last_start % 1024], 2);
    chk(wr_a[(last_start + 1) % 1024] == 12'hFFD && wr_d[(last_start + 1) % 1024] == 16'h0102,
        "R8", "inner call return address at FFD", wr_d[(last_start + 1) % 1024], 16'h0102);
    chk(wr_a[(last_start + 2) % 1024] == 12'hFFC && wr_d[(last_start + 2) % 1024] == 16'h0006,
        "R7", "push below nested frames", wr_a[(last_start + 2) % 1024], 12'hFFC);
    chk(dbg_sp == 12'hFFF && dbg_pc == 12'h004 && dbg_acc == 16'd6,
        "R9", "nested returns restore sp", dbg_sp, 12'hFFF);

    // D3: JZ taken then not taken
    clear_img();
    img[12'h800] = 16'h0000;
    img[0] = ins(4'h0, 12'h800);
    img[1] = ins(4'h7, 12'h003);
    img[2] = ins(4'h4, 12'h000);
    img[3] = ins(4'h4, 12'h000);
    img[4] = ins(4'h7, 12'h007);
    img[5] = ins(4'h1, 12'h801);
    img[6] = ins(4'hF, 12'h000);
    img[7] = ins(4'h1, 12'h802);
    img[8] = ins(4'hF, 12'h000);
    run("R6", 1'b0);
    chk(dbg_acc == 16'd1 && dbg_pc == 12'h007 && wr_a[last_start % 1024] == 12'h801,
        "R6", "jz taken on zero, falls through on nonzero", dbg_pc, 7);

    // D4: accumulator wrap and pop at stack top
    clear_img();
    img[12'h800] = 16'hFFFF;
    img[12'hFFF] = 16'h1234;
    img[0] = ins(4'h0, 12'h800);
    img[1] = ins(4'h4, 12'h000);
    img[2] = ins(4'h7, 12'h004);
    img[3] = ins(4'hF, 12'h000);
    img[4] = ins(4'h5, 12'h000);
    img[5] = ins(4'h1, 12'h801);
    img[6] = ins(4'h9, 12'h000);
    img[7] = ins(4'hF, 12'h000);
    run("R5", 1'b0);
    chk(wr_d[last_start % 1024] == 16'hFFFF, "R5", "0 minus 1 wraps", wr_d[last_start % 1024], 16'hFFFF);
    chk(dbg_acc == 16'h1234 && dbg_sp == 12'h000, "R7", "pop at FFF wraps sp to 000", dbg_sp, 0);

    // D5: unused opcodes are no-ops
    clear_img();
    img[12'h800] = 16'd7;
    img[0] = ins(4'h0, 12'h800);
    img[1] = ins(4'hC, 12'h123);
    img[2] = ins(4'hD, 12'h800);
    img[3] = ins(4'hE, 12'h000);
    img[4] = ins(4'hF, 12'h000);
    run("R11", 1'b0);
    chk(dbg_acc == 16'd7 && dbg_pc == 12'h005 && dbg_sp == 12'hFFF,
        "R11", "reserved opcodes leave state", dbg_acc, 7);

    // seeded random programs
    for (int p = 0; p < 14; p++) begin
      gen_random();
      run((p % 2) ? "R2" : "R4", 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule